// File: doc/BRIEF.md
# Peripheral Clock Mux-Divide-Gate Slice

This block is one clock-generation slice for a single peripheral. Several reference enable strobes arrive on `ref_en`, and each one marks a cycle of a slower reference in the common system clock domain. A select field picks one of them. The picked strobe stream is divided by two cascaded divider stages whose ratios multiply. A disable bit then gates the result. The output `clk_en` is a one-cycle enable pulse train, not a derived clock, so the peripheral logic stays in the single system clock domain.

Each divider stage takes a 3-bit code. Codes 1 through 6 divide by their own value, and codes 0 and 7 are invalid. The `ratio` port reports the effective ratio for readback, and `invalid_cfg` flags a configuration that cannot produce pulses. A build parameter selects a second variant with a single stage, where code 0 means divide by 2 and code 1 means divide by 4. The strobe inputs and `clk_en` are plain strobes with no back-pressure. The peripheral samples `clk_en` in the cycle it is high, and a pulse is never held or retried.

Top module: `periph_clk_slice`

## Requirements
- R1: `clk_en` responds only to strobes on `ref_en[src_sel]`. Strobes on the sources that are not selected have no effect on the output or on the count.
- R2: In the cascade variant (default), with stage codes a and b both in 1..6, `clk_en` pulses once for every a*b strobes on the selected source.
- R3: A stage code of 0 or 7 makes that stage invalid. In that case `ratio` is 0, `invalid_cfg` is 1, and `clk_en` stays low whatever strobes arrive.
- R4: `ratio` is combinational and equals the product of the two decoded stage values, and `invalid_cfg` is 1 exactly when `ratio` is 0.
- R5: While `gate_off` is 1, no pulse appears on `clk_en`. The divider keeps counting strobes, so the pulse phase is the same after `gate_off` returns to 0.
- R6: Any change of `src_sel`, `div_code_a` or `div_code_b` restarts the count from zero. A strobe that arrives in the same cycle as the change is dropped.
- R7: A pulse appears on `clk_en` one cycle after the strobe that completes the count and lasts one cycle. `clk_en` is never high unless the selected source strobed in the cycle before.
- R8: The reset `rst` is synchronous and active-high. It clears the count and holds `clk_en` low, and counting restarts from zero after reset.
- R9: In the single-stage variant (`DIV_STYLE` = `DIV_HALF_TABLE`), `div_code_a` = 0 divides by 2 and `div_code_a` = 1 divides by 4. Every other value of `div_code_a` is invalid, and `div_code_b` has no effect on the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | NUM_SRC (4) | One enable strobe per reference source |
| src_sel | input | SEL_W (2) | Index of the source to divide |
| div_code_a | input | CODE_W (3) | First divider stage code |
| div_code_b | input | CODE_W (3) | Second divider stage code (cascade variant) |
| gate_off | input | 1 | 1 suppresses output pulses |
| clk_en | output | 1 | Divided, gated enable pulse |
| ratio | output | 2*CODE_W (6) | Effective divide ratio, 0 when invalid |
| invalid_cfg | output | 1 | Configuration cannot produce pulses |

## Verification
The hardest case to reach from the ports is a count that is only partly done when something happens to it. Examples are a gate that closes while the count is partway through its cycle, a configuration change or a reset that lands after a few strobes, and a strobe that arrives in the same cycle as the change. The stimulus therefore builds up a known partial count with strobe patterns that mix in noise on the other sources. It then applies the disruption and counts how many more selected strobes are needed before the next pulse. The default variant and the single-stage variant are driven with the same inputs. This makes `div_code_b` appear to the single-stage instance as an input it has to ignore.

// File: rtl/pclk_slice_pkg.sv
package pclk_slice_pkg;

  typedef enum logic {
    DIV_CASCADE    = 1'b0,
    DIV_HALF_TABLE = 1'b1
  } div_style_e;

  localparam int STAGE_MAX = 6;

  // Divider code to stage value; anything outside 1..STAGE_MAX decodes to 0.
  function automatic int stage_value(input int code);
    return (code >= 1 && code <= STAGE_MAX) ? code : 0;
  endfunction

  // Single-stage code: 0 means /2, 1 means /4, others decode to 0.
  function automatic int half_value(input int code);
    if (code == 0) return 2;
    if (code == 1) return 4;
    return 0;
  endfunction

endpackage

// File: rtl/pclk_ratio_decode.sv
module pclk_ratio_decode #(
  parameter int CODE_W = 3,
  parameter pclk_slice_pkg::div_style_e DIV_STYLE = pclk_slice_pkg::DIV_CASCADE,
  localparam int RATIO_W = 2 * CODE_W
) (
  input  logic [CODE_W-1:0]  code_a,
  input  logic [CODE_W-1:0]  code_b,
  output logic [CODE_W-1:0]  val_a,
  output logic [CODE_W-1:0]  val_b,
  output logic [RATIO_W-1:0] ratio,
  output logic               bad
);

  generate
    if (DIV_STYLE == pclk_slice_pkg::DIV_HALF_TABLE) begin : g_half
      logic unused_b;
      assign unused_b = ^code_b;
      assign val_a = CODE_W'(pclk_slice_pkg::half_value(int'(code_a)));
      assign val_b = CODE_W'(1);
    end else begin : g_casc
      assign val_a = CODE_W'(pclk_slice_pkg::stage_value(int'(code_a)));
      assign val_b = CODE_W'(pclk_slice_pkg::stage_value(int'(code_b)));
    end
  endgenerate

  assign ratio = RATIO_W'(val_a) * RATIO_W'(val_b);
  assign bad   = (ratio == '0);

endmodule

// File: rtl/pclk_div_stage.sv
module pclk_div_stage #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              tick,
  input  logic [CODE_W-1:0] div_val,
  output logic              carry
);

  logic [CODE_W-1:0] cnt;
  logic              at_last;
  logic              live;

  assign live    = (div_val != '0);
  assign at_last = (cnt == div_val - CODE_W'(1));
  assign carry   = tick & live & at_last;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick && live) begin
      cnt <= at_last ? '0 : cnt + CODE_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!clear && live) |-> (cnt < div_val)); // R2

endmodule

// File: rtl/periph_clk_slice.sv
module periph_clk_slice #(
  parameter int NUM_SRC = 4,
  parameter int CODE_W  = 3,
  parameter pclk_slice_pkg::div_style_e DIV_STYLE = pclk_slice_pkg::DIV_CASCADE,
  localparam int SEL_W   = $clog2(NUM_SRC),
  localparam int RATIO_W = 2 * CODE_W,
  localparam int CFG_W   = SEL_W + 2 * CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ref_en,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [CODE_W-1:0]  div_code_a,
  input  logic [CODE_W-1:0]  div_code_b,
  input  logic               gate_off,
  output logic               clk_en,
  output logic [RATIO_W-1:0] ratio,
  output logic               invalid_cfg
);

  // Source selection; an out-of-range index selects nothing.
  logic sel_tick;
  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel == SEL_W'(i)) sel_tick = ref_en[i];
    end
  end

  // Configuration change detection restarts the dividers.
  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;

  assign cfg_now = {src_sel, div_code_a, div_code_b};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end

  // Code decode and ratio readback.
  logic [CODE_W-1:0] val_a;
  logic [CODE_W-1:0] val_b;
  logic              bad;

  pclk_ratio_decode #(
    .CODE_W    (CODE_W),
    .DIV_STYLE (DIV_STYLE)
  ) u_decode (
    .code_a (div_code_a),
    .code_b (div_code_b),
    .val_a  (val_a),
    .val_b  (val_b),
    .ratio  (ratio),
    .bad    (bad)
  );

  assign invalid_cfg = bad;

  logic clear;
  assign clear = cfg_chg | bad;

  // First stage always present.
  logic carry_a;
  logic final_tick;

  pclk_div_stage #(.CODE_W(CODE_W)) u_stage_a (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .tick    (sel_tick),
    .div_val (val_a),
    .carry   (carry_a)
  );

  // Second stage only in the cascade variant.
  generate
    if (DIV_STYLE == pclk_slice_pkg::DIV_CASCADE) begin : g_stage_b
      pclk_div_stage #(.CODE_W(CODE_W)) u_stage_b (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .tick    (carry_a),
        .div_val (val_b),
        .carry   (final_tick)
      );
    end else begin : g_single
      logic unused_vb;
      assign unused_vb  = ^val_b;
      assign final_tick = carry_a;
    end
  endgenerate

  // Registered, gated output pulse.
  logic en_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      en_q <= final_tick & ~gate_off & ~clear;
    end
  end

  assign clk_en = en_q;

  AST_RESET_HOLDS_LOW: assert property (@(posedge clk)
    rst |=> !clk_en); // R8

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    gate_off |=> !clk_en); // R5

  AST_INVALID_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    invalid_cfg |=> !clk_en); // R3

  AST_CHANGE_DROPS: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> !clk_en); // R6

  AST_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !sel_tick |=> !clk_en); // R7

endmodule

// File: tb/test_periph_clk_slice.sv
module test_periph_clk_slice;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ref_en = '0;
  logic [1:0] src_sel = '0;
  logic [2:0] div_a = 3'd2;
  logic [2:0] div_b = 3'd3;
  logic       gate_off = 1'b0;

  logic       en_c, inv_c, en_h, inv_h;
  logic [5:0] ratio_c, ratio_h;

  periph_clk_slice i_periph_clk_slice (
    .clk(clk), .rst(rst), .ref_en(ref_en), .src_sel(src_sel),
    .div_code_a(div_a), .div_code_b(div_b), .gate_off(gate_off),
    .clk_en(en_c), .ratio(ratio_c), .invalid_cfg(inv_c)
  );

  periph_clk_slice #(.DIV_STYLE(pclk_slice_pkg::DIV_HALF_TABLE)) i_periph_clk_slice_half (
    .clk(clk), .rst(rst), .ref_en(ref_en), .src_sel(src_sel),
    .div_code_a(div_a), .div_code_b(div_b), .gate_off(gate_off),
    .clk_en(en_h), .ratio(ratio_h), .invalid_cfg(inv_h)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { bit en; string tag; } exp_t;
  exp_t q_c[$];
  exp_t q_h[$];
  exp_t e_c, e_h;

  int checks = 0;
  int fails  = 0;
  int m_c = 0;
  int m_h = 0;
  bit done = 0;

  task automatic note(input bit ok, input string tag, input string what,
                      input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, expv);
    end
  endtask

  function automatic int n_casc(input int a, input int b);
    int va = (a >= 1 && a <= 6) ? a : 0;
    int vb = (b >= 1 && b <= 6) ? b : 0;
    return va * vb;
  endfunction

  function automatic int n_half(input int a);
    return (a == 0) ? 2 : (a == 1) ? 4 : 0;
  endfunction

  function automatic bit tick_model(inout int m, input int n, input bit sp);
    if (n == 0 || !sp) return 1'b0;
    m++;
    if (m == n) begin
      m = 0;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic push0(input string tag);
    q_c.push_back('{1'b0, tag});
    q_h.push_back('{1'b0, tag});
  endtask

  // Driver: one strobe pattern per cycle, expected output queued.
  task automatic step(input logic [3:0] p, input string tag);
    bit sp, fc, fh;
    @(negedge clk);
    ref_en = p;
    sp = p[src_sel];
    fc = tick_model(m_c, n_casc(div_a, div_b), sp);
    fh = tick_model(m_h, n_half(div_a), sp);
    q_c.push_back('{fc & !gate_off, tag});
    q_h.push_back('{fh & !gate_off, tag});
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [2:0] a,
                         input logic [2:0] b, input logic [3:0] p, input string tag);
    int nc, nh;
    @(negedge clk);
    ref_en = p;           // a strobe here must be dropped (R6)
    src_sel = s; div_a = a; div_b = b;
    m_c = 0; m_h = 0;
    push0(tag);
    nc = n_casc(a, b);
    nh = n_half(a);
    #1;
    note(ratio_c == 6'(nc), "R4", "ratio", ratio_c, nc);
    note(inv_c == (nc == 0), "R3", "invalid_cfg", inv_c, nc == 0);
    note(ratio_h == 6'(nh), "R9", "ratio_half", ratio_h, nh);
    note(inv_h == (nh == 0), "R9", "invalid_half", inv_h, nh == 0);
  endtask

  task automatic set_gate(input bit g, input string tag);
    @(negedge clk);
    ref_en = '0;
    gate_off = g;
    push0(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; ref_en = '0;
    m_c = 0; m_h = 0;
    push0(tag);
    @(negedge clk);
    rst = 1'b0;
    push0(tag);
  endtask

  // Monitor: compares each produced cycle against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_c.size() > 0) begin
        e_c = q_c.pop_front();
        note(en_c === e_c.en, e_c.tag, "clk_en", int'(en_c), int'(e_c.en));
      end
      if (q_h.size() > 0) begin
        e_h = q_h.pop_front();
        note(en_h === e_h.en, e_h.tag, "clk_en_half", int'(en_h), int'(e_h.en));
      end
    end
  end

  // Watchdog.
  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: strobes on every source during reset leave the output low.
    ref_en = 4'hF;
    repeat (4) begin
      @(negedge clk);
      note(en_c == 1'b0, "R8", "clk_en_in_reset", en_c, 0);
      note(en_h == 1'b0, "R8", "clk_en_half_in_reset", en_h, 0);
    end
    @(negedge clk);
    rst = 1'b0; ref_en = '0;
    m_c = 0; m_h = 0;

    // R1, R2, R4: ratio 6 on source 0, noise on the others first.
    set_cfg(2'd0, 3'd2, 3'd3, 4'b0000, "R4");
    for (int i = 0; i < 10; i++) step(4'b1110, "R1");
    for (int i = 0; i < 18; i++) step(4'b0001, "R2");

    // R2: ratio 20 on source 2 every other cycle, noise always on.
    set_cfg(2'd2, 3'd4, 3'd5, 4'b0000, "R4");
    for (int i = 0; i < 60; i++) step((i % 2 == 0) ? 4'b1111 : 4'b1011, "R2");

    // R7: ratio 1, back-to-back and isolated strobes.
    set_cfg(2'd3, 3'd1, 3'd1, 4'b0000, "R4");
    for (int i = 0; i < 12; i++) step((i % 3 == 2) ? 4'b0111 : 4'b1000, "R7");

    // R3: invalid codes 7 and 0 produce no pulses.
    set_cfg(2'd1, 3'd7, 3'd3, 4'b0000, "R3");
    for (int i = 0; i < 10; i++) step(4'b0010, "R3");
    set_cfg(2'd1, 3'd3, 3'd0, 4'b0000, "R3");
    for (int i = 0; i < 10; i++) step(4'b0010, "R3");

    // R5: gate closes mid-count, counting continues.
    set_cfg(2'd1, 3'd3, 3'd1, 4'b0000, "R4");
    for (int i = 0; i < 4; i++) step(4'b0010, "R5");
    set_gate(1'b1, "R5");
    for (int i = 0; i < 5; i++) step(4'b0010, "R5");
    set_gate(1'b0, "R5");
    for (int i = 0; i < 7; i++) step(4'b0010, "R5");

    // R6: partial count then code change; strobe in change cycle dropped.
    set_cfg(2'd1, 3'd2, 3'd2, 4'b0000, "R4");
    for (int i = 0; i < 3; i++) step(4'b0010, "R6");
    set_cfg(2'd1, 3'd4, 3'd1, 4'b0010, "R6");
    for (int i = 0; i < 9; i++) step(4'b0010, "R6");
    set_cfg(2'd0, 3'd4, 3'd1, 4'b0001, "R6");
    for (int i = 0; i < 5; i++) step(4'b0001, "R6");

    // R8: reset mid-count restarts from zero.
    for (int i = 0; i < 2; i++) step(4'b0001, "R8");
    do_reset("R8");
    for (int i = 0; i < 9; i++) step(4'b0001, "R8");

    // R9: single-stage table, div_code_b ignored there.
    set_cfg(2'd3, 3'd1, 3'd7, 4'b0000, "R9");
    for (int i = 0; i < 13; i++) step(4'b1000, "R9");
    set_cfg(2'd2, 3'd0, 3'd5, 4'b0000, "R9");
    for (int i = 0; i < 9; i++) step(4'b0100, "R9");
    set_cfg(2'd2, 3'd0, 3'd2, 4'b0000, "R9");
    for (int i = 0; i < 7; i++) step(4'b0100, "R9");
    set_cfg(2'd2, 3'd5, 3'd2, 4'b0000, "R9");
    for (int i = 0; i < 12; i++) step(4'b0100, "R9");

    @(negedge clk);
    ref_en = '0;
    repeat (3) @(negedge clk);
    note(q_c.size() == 0 && q_h.size() == 0, "R7", "queue_drained",
         q_c.size() + q_h.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule